// File: doc/BRIEF.md
# Bypassing Circular FIFO

This block is a first-in first-out buffer built on a circular register array. It has one write port and one read port, and both can act in the same clock cycle. The read side is combinational. A read request returns its data and a valid strobe in the same cycle, taken from the entry at the head of the buffer.

When the buffer holds nothing and a read and a write arrive in the same cycle, the incoming word goes straight to the read port and is not stored. Neither pointer moves, the occupancy does not change, and no error is raised.

The block shows whether it is empty or full. It also flags two kinds of misuse with one-cycle error pulses:
- a read with nothing to return;
- a write with no room.

In both cases the offending request is dropped. Depth and word width are parameters.

Top module: `byp_fifo`

## Requirements
- R1: After reset the occupancy is zero: `empty`=1, `full`=0, and with no requests `rd_valid`, `underflow_err` and `overflow_err` are all 0.
- R2: `empty` is 1 exactly when the occupancy is 0, and `full` is 1 exactly when the occupancy equals DEPTH. Both reflect the state at the start of the cycle.
- R3: A read on a non-empty buffer raises `rd_valid` in the same cycle. Words come out in the order they were stored.
- R4: A read and a write in the same cycle on an empty buffer drive `wr_data` onto `rd_data` with `rd_valid`=1 in that cycle. No error is raised, and the buffer is still empty in the next cycle.
- R5: A read on an empty buffer without a write raises `underflow_err` for that cycle, with `rd_valid`=0. The state is unchanged.
- R6: A write on a full buffer raises `overflow_err` for that cycle, and the word is discarded. It never appears at the read port.
- R7: A stored write and a memory read in the same cycle leave the occupancy unchanged.
- R8: A read and a write in the same cycle on a full buffer serve the read, drop the write with `overflow_err`, and leave DEPTH-1 words.
- R9: The read and write positions wrap modulo DEPTH, and the order of words is kept across any number of wraps.
- R10: The error flags are pulses. With no request in a cycle, both error flags are 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Word read, valid when rd_valid is 1 |
| rd_valid | output | 1 | Read served this cycle, from memory or bypass |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| underflow_err | output | 1 | Read dropped: buffer empty and no write |
| overflow_err | output | 1 | Write dropped: buffer full |

## Verification
The read/write pair is applied in all four combinations at each occupancy level: empty, partly filled and full. This separates the bypass case from the underflow case, and the overflow case from a plain concurrent transfer. A long interleaved run, with distinct words at an occupancy that moves around, makes the pointers wrap several times. An off-by-one in the wrap or a mistake in the order of words then shows up as wrong data. Idle cycles after each error check that the error flags are pulses rather than held levels.

// File: rtl/byp_fifo_pkg.sv
package byp_fifo_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_BYP  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic    mem_wr;
        logic    mem_rd;
        rd_src_e src;
        logic    under_err;
        logic    over_err;
    } fifo_op_t;

    // Resolve one cycle's requests against the state at cycle start.
    function automatic fifo_op_t decode_op(logic wr, logic rd, logic is_empty, logic is_full);
        fifo_op_t op;
        logic     pass;
        pass         = rd && is_empty && wr;
        op.mem_rd    = rd && !is_empty;
        op.mem_wr    = wr && !is_full && !pass;
        op.under_err = rd && is_empty && !wr;
        op.over_err  = wr && is_full;
        if (op.mem_rd)    op.src = SRC_MEM;
        else if (pass)    op.src = SRC_BYP;
        else              op.src = SRC_NONE;
        return op;
    endfunction

endpackage

// File: rtl/byp_fifo_ptr.sv
module byp_fifo_ptr #(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/byp_fifo_mem.sv
module byp_fifo_mem #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                cells[i] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/byp_fifo_cnt.sv
module byp_fifo_cnt #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] level,
    output logic          is_empty,
    output logic          is_full
);
    logic [CW-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   level_q <= level_q + CW'(1);
                2'b01:   level_q <= level_q - CW'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign level    = level_q;
    assign is_empty = (level_q == '0);
    assign is_full  = (level_q == CW'(DEPTH));
endmodule

// File: rtl/byp_fifo.sv
module byp_fifo
    import byp_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         empty,
    output logic         full,
    output logic         underflow_err,
    output logic         overflow_err
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fifo_op_t      op;
    logic          is_empty;
    logic          is_full;
    logic [CW-1:0] level;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [W-1:0]  mem_rdata;

    byp_fifo_cnt #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (op.mem_wr),
        .dec      (op.mem_rd),
        .level    (level),
        .is_empty (is_empty),
        .is_full  (is_full)
    );

    always_comb op = decode_op(wr_en, rd_en, is_empty, is_full);

    byp_fifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
        .clk (clk),
        .rst (rst),
        .adv (op.mem_wr),
        .ptr (wptr)
    );

    byp_fifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
        .clk (clk),
        .rst (rst),
        .adv (op.mem_rd),
        .ptr (rptr)
    );

    byp_fifo_mem #(.DEPTH(DEPTH), .W(W), .AW(PW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (op.mem_wr),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (mem_rdata)
    );

    assign rd_data       = (op.src == SRC_BYP) ? wr_data : mem_rdata;
    assign rd_valid      = (op.src != SRC_NONE);
    assign empty         = is_empty;
    assign full          = is_full;
    assign underflow_err = op.under_err;
    assign overflow_err  = op.over_err;

    logic unused_level;
    assign unused_level = ^level;
endmodule

// File: rtl/byp_fifo_chk.sv
module byp_fifo_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         rd_en,
    input logic [W-1:0] rd_data,
    input logic         rd_valid,
    input logic         empty,
    input logic         full,
    input logic         underflow_err,
    input logic         overflow_err
);
    p_empty_full_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |-> (rd_valid && !underflow_err));

    p_bypass_data_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && empty) |-> (rd_valid && rd_data == wr_data && !underflow_err && !overflow_err));

    p_bypass_stays_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && empty) |=> empty);

    p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && empty) |-> (underflow_err && !rd_valid));

    p_underflow_hold_r5: assert property (@(posedge clk) disable iff (rst)
        underflow_err |=> empty);

    p_overflow_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |-> overflow_err);

    p_overflow_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> full);

    p_concurrent_level_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && !empty && !full) |=> (empty == $past(empty) && full == $past(full)));

    p_full_rdwr_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && full) |=> !full);

    p_idle_no_err_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (!underflow_err && !overflow_err && !rd_valid));
endmodule

bind byp_fifo byp_fifo_chk #(.W(W)) u_byp_fifo_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .empty         (empty),
    .full          (full),
    .underflow_err (underflow_err),
    .overflow_err  (overflow_err)
);

// File: tb/test_byp_fifo.sv
`timescale 1ns/1ps
module test_byp_fifo;
    localparam int DEPTH = 4;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid, empty, full, underflow_err, overflow_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [W-1:0] mq[$];

    always #2.5 clk = ~clk;

    byp_fifo #(.DEPTH(DEPTH), .W(W)) i_byp_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full),
        .underflow_err(underflow_err), .overflow_err(overflow_err)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare against the model, commit at rising edge.
    task automatic step(input logic w, input logic [W-1:0] d, input logic r, input string req);
        bit e_empty, e_full, byp, e_under, e_over, e_valid;
        logic [W-1:0] e_data;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r;
        #1;
        e_empty = (mq.size() == 0);
        e_full  = (mq.size() == DEPTH);
        byp     = r && w && e_empty;
        e_under = r && !w && e_empty;
        e_over  = w && e_full;
        e_valid = byp || (r && !e_empty);
        e_data  = byp ? d : (e_empty ? '0 : mq[0]);
        check(empty == e_empty, req, "empty", empty, e_empty);
        check(full == e_full, req, "full", full, e_full);
        check(underflow_err == e_under, req, "underflow_err", underflow_err, e_under);
        check(overflow_err == e_over, req, "overflow_err", overflow_err, e_over);
        check(rd_valid == e_valid, req, "rd_valid", rd_valid, e_valid);
        if (e_valid) check(rd_data == e_data, req, "rd_data", rd_data, e_data);
        if (r && !e_empty) void'(mq.pop_front());
        if (w && !e_full && !byp) mq.push_back(d);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        mq.delete();
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step(1'b0, '0, 1'b0, "R1");
        step(1'b0, '0, 1'b0, "R10");
    endtask

    task automatic t_fill_drain;
        for (int i = 0; i < DEPTH; i++) step(1'b1, W'(8'h10 + i), 1'b0, "R2");
        step(1'b0, '0, 1'b0, "R2");
        step(1'b1, 8'hEE, 1'b0, "R6");
        step(1'b0, '0, 1'b0, "R10");
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, "R3");
        step(1'b0, '0, 1'b0, "R2");
    endtask

    task automatic t_bypass;
        step(1'b1, 8'hA5, 1'b1, "R4");
        step(1'b1, 8'h5A, 1'b1, "R4");
        step(1'b0, '0, 1'b0, "R4");
    endtask

    task automatic t_underflow;
        step(1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b0, "R10");
        step(1'b1, 8'h33, 1'b0, "R5");
        step(1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, "R5");
    endtask

    task automatic t_concurrent;
        step(1'b1, 8'h41, 1'b0, "R7");
        step(1'b1, 8'h42, 1'b0, "R7");
        for (int i = 0; i < 5; i++) step(1'b1, W'(8'h50 + i), 1'b1, "R7");
        step(1'b0, '0, 1'b1, "R7");
        step(1'b0, '0, 1'b1, "R7");
        step(1'b0, '0, 1'b1, "R7");
    endtask

    task automatic t_full_rdwr;
        for (int i = 0; i < DEPTH; i++) step(1'b1, W'(8'h60 + i), 1'b0, "R8");
        step(1'b1, 8'hBB, 1'b1, "R8");
        step(1'b1, 8'h70, 1'b0, "R8");
        step(1'b1, 8'hCC, 1'b1, "R8");
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, "R8");
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 60; i++) begin
            logic w, r;
            w = ((i % 3) != 2);
            r = ((i % 4) == 1) || ((i % 5) == 3) || (i > 45);
            step(w, W'(i * 7 + 3), r, "R9");
        end
        while (mq.size() > 0) step(1'b0, '0, 1'b1, "R9");
        step(1'b0, '0, 1'b0, "R9");
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_bypass();
        t_underflow();
        t_concurrent();
        t_full_rdwr();
        t_wrap();
        t_reset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule